// File: doc/BRIEF.md
# Modulator Clock and Sync Controller

This block sits between an oversampling modulator and its decimating filter. From the master clock it derives the modulator sampling clock at one quarter of the master rate. Once per modulator period it hands the filter one bit, with a one-cycle valid strobe. It also keeps a decimation-phase counter that tells the filter where each bit falls inside the current output period.

A rising edge on the sync input re-aligns the filter. The block issues a clear pulse and restarts the decimation phase, but only when the phase is not already aligned. A power-down request is qualified on the falling master-clock edge. While it is active, the modulator clock and the convolution freeze in place. After power-down ends, the modulator clock runs again, but no bits reach the filter until a sync arrives.

A select input picks the filter source: live modulator data or a user test stream. The modulator overrange flag is sampled on the rising edge. It produces an error event pulse and a sticky active-low error output.

Top module: `mod_clk_sync_ctrl`

## Requirements
- R1: `mclk_o` has a period of 4 master cycles. It is high during divider phases 0 and 1 and low during phases 2 and 3. It is high right after reset.
- R2: `bit_vld_o` is a one-cycle pulse once per modulator period while the block is running. It rises one cycle after divider phase 3.
- R3: With `src_sel_i` high, the bit that goes with the strobe is `tdata_i`; with it low, the bit is `mdata_i`. The value is sampled on the rising edge in divider phase 3.
- R4: `dec_phase_o` advances by one with each delivered bit and returns to 0 after reaching `ratio_i`-1. For `ratio_i` values 0 and 1 it stays at 0.
- R5: A rising edge of `sync_i` seen at a rising clock edge acts only if the block is halted or `dec_phase_o` is nonzero. In that case `clr_o` pulses for one cycle, starting one cycle later, and the phase returns to 0. If the block is running with phase 0, the edge has no effect.
- R6: `pwrdn_i` is sampled on the falling clock edge. From the next rising edge on, `mclk_o` and `dec_phase_o` hold their values and no strobe is issued. Sync edges are ignored during this time.
- R7: After power-down ends, `mclk_o` resumes but strobes stay off and the phase holds, until a sync edge clears the filter.
- R8: `mflg_i` is sampled on the rising edge. The first cycle it is seen high, `err_evt_o` pulses for one cycle. `err_n_o` goes low and stays low until reset.
- R9: Reset leaves the divider at phase 0, the phase counter at 0, no power-down pending, `err_n_o` high, and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrdn_i | input | 1 | Power-down request, sampled on the falling edge |
| sync_i | input | 1 | Sync request; its rising edge acts |
| src_sel_i | input | 1 | Filter source select: 1 test data, 0 modulator data |
| mdata_i | input | 1 | Modulator bit stream |
| tdata_i | input | 1 | User test bit stream |
| mflg_i | input | 1 | Modulator overrange flag |
| ratio_i | input | DEC_W | Decimation ratio |
| mclk_o | output | 1 | Modulator clock, master rate divided by 4 |
| bit_vld_o | output | 1 | Bit strobe to the filter |
| bit_o | output | 1 | Selected filter input bit |
| clr_o | output | 1 | Filter clear pulse |
| dec_phase_o | output | DEC_W | Decimation phase |
| err_evt_o | output | 1 | Overrange error event pulse |
| err_n_o | output | 1 | Sticky error, active low |

## Verification
The hardest situation to reach is the exit from power-down. Here the divider is running again but the convolution is halted, and a sync edge must restart it even though the phase already reads zero. The test must also confirm that a sync held high across the exit does nothing until it makes a new edge. The stimulus switches `pwrdn_i` at random, a few cycles away from the falling edge, and overlays sparse sync pulses and changes of a small decimation ratio. Both the halted-then-sync path and the aligned-sync no-op therefore recur many times. A cycle model in the bench tracks the expected outputs from the requirements.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } conv_st_e;
endpackage

// File: rtl/mcs_pd_qual.sv
`timescale 1ns/1ps
// power-down request qualified on the falling master edge
module mcs_pd_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_i,
  output logic pd_o
);
  logic pd_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= 1'b0;
    else         pd_q <= pwrdn_i;
  end

  assign pd_o = pd_q;
endmodule

// File: rtl/mcs_clk_div.sv
`timescale 1ns/1ps
module mcs_clk_div #(
  parameter int DIV          = 4,
  parameter int STROBE_PHASE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  output logic mclk_o,
  output logic strobe_ph_o
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] HALF = DIV_W'(DIV / 2);
  localparam logic [DIV_W-1:0] SPH  = DIV_W'(STROBE_PHASE);

  logic [DIV_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (!freeze_i) begin
      ph_q <= (ph_q == LAST) ? '0 : ph_q + DIV_W'(1);
    end
  end

  assign mclk_o      = (ph_q < HALF);
  assign strobe_ph_o = (ph_q == SPH);
endmodule

// File: rtl/mcs_conv_ctl.sv
`timescale 1ns/1ps
module mcs_conv_ctl
  import mcs_pkg::*;
#(
  parameter int DEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_i,
  input  logic             strobe_ph_i,
  input  logic             sync_i,
  input  logic [DEC_W-1:0] ratio_i,
  output logic             take_o,
  output logic             clr_o,
  output logic [DEC_W-1:0] dec_phase_o
);
  conv_st_e         st_q;
  logic             sync_q;
  logic             clr_q;
  logic [DEC_W-1:0] dec_q;
  logic             sync_edge;
  logic             clr_now;
  logic             running;
  logic [DEC_W:0]   dec_inc;
  logic             dec_wrap;

  assign sync_edge = sync_i & ~sync_q;
  assign running   = ~freeze_i & (st_q == ST_RUN);
  assign take_o    = running & strobe_ph_i;
  // an edge already in step with the decimation period is swallowed
  assign clr_now   = ~freeze_i & sync_edge & ((st_q == ST_HALT) | (dec_q != '0));
  assign dec_inc   = {1'b0, dec_q} + (DEC_W+1)'(1);
  assign dec_wrap  = dec_inc >= {1'b0, ratio_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      sync_q <= 1'b0;
      clr_q  <= 1'b0;
      dec_q  <= '0;
    end else begin
      sync_q <= sync_i;
      clr_q  <= clr_now;
      if (freeze_i) begin
        st_q <= ST_HALT;
      end else if (clr_now) begin
        st_q  <= ST_RUN;
        dec_q <= '0;
      end else if (take_o) begin
        dec_q <= dec_wrap ? '0 : dec_inc[DEC_W-1:0];
      end
    end
  end

  assign clr_o       = clr_q;
  assign dec_phase_o = dec_q;
endmodule

// File: rtl/mcs_bit_cap.sv
`timescale 1ns/1ps
module mcs_bit_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic src_sel_i,
  input  logic mdata_i,
  input  logic tdata_i,
  output logic vld_o,
  output logic bit_o
);
  logic vld_q;
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= take_i;
      if (take_i) bit_q <= src_sel_i ? tdata_i : mdata_i;
    end
  end

  assign vld_o = vld_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/mcs_err_mon.sv
`timescale 1ns/1ps
module mcs_err_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mflg_i,
  output logic evt_o,
  output logic err_n_o
);
  logic flg_q;
  logic evt_q;
  logic err_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q   <= 1'b0;
      evt_q   <= 1'b0;
      err_n_q <= 1'b1;
    end else begin
      flg_q <= mflg_i;
      evt_q <= mflg_i & ~flg_q;
      if (mflg_i) err_n_q <= 1'b0;
    end
  end

  assign evt_o   = evt_q;
  assign err_n_o = err_n_q;
endmodule

// File: rtl/mod_clk_sync_ctrl.sv
`timescale 1ns/1ps
module mod_clk_sync_ctrl #(
  parameter int DIV          = 4,
  parameter int STROBE_PHASE = 3,
  parameter int DEC_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwrdn_i,
  input  logic             sync_i,
  input  logic             src_sel_i,
  input  logic             mdata_i,
  input  logic             tdata_i,
  input  logic             mflg_i,
  input  logic [DEC_W-1:0] ratio_i,
  output logic             mclk_o,
  output logic             bit_vld_o,
  output logic             bit_o,
  output logic             clr_o,
  output logic [DEC_W-1:0] dec_phase_o,
  output logic             err_evt_o,
  output logic             err_n_o
);
  logic pd_q;
  logic strobe_ph;
  logic take;

  mcs_pd_qual u_pd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_i (pwrdn_i),
    .pd_o    (pd_q)
  );

  mcs_clk_div #(.DIV(DIV), .STROBE_PHASE(STROBE_PHASE)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .freeze_i    (pd_q),
    .mclk_o      (mclk_o),
    .strobe_ph_o (strobe_ph)
  );

  mcs_conv_ctl #(.DEC_W(DEC_W)) u_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .freeze_i    (pd_q),
    .strobe_ph_i (strobe_ph),
    .sync_i      (sync_i),
    .ratio_i     (ratio_i),
    .take_o      (take),
    .clr_o       (clr_o),
    .dec_phase_o (dec_phase_o)
  );

  mcs_bit_cap u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .src_sel_i (src_sel_i),
    .mdata_i   (mdata_i),
    .tdata_i   (tdata_i),
    .vld_o     (bit_vld_o),
    .bit_o     (bit_o)
  );

  mcs_err_mon u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mflg_i  (mflg_i),
    .evt_o   (err_evt_o),
    .err_n_o (err_n_o)
  );
endmodule

// File: rtl/mcs_checker.sv
`timescale 1ns/1ps
module mcs_checker #(
  parameter int DEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_i,
  input logic             mclk_i,
  input logic             bit_vld_i,
  input logic             clr_i,
  input logic [DEC_W-1:0] dec_phase_i,
  input logic             err_evt_i,
  input logic             err_n_i
);
  a_r6_mclk_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> $stable(mclk_i));

  a_r6_phase_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> $stable(dec_phase_i));

  a_r6_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !bit_vld_i);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_i |=> !bit_vld_i);

  a_r5_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> dec_phase_i == '0);

  a_r4_phase_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dec_phase_i) |-> (bit_vld_i || clr_i));

  a_r8_evt_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |-> !err_n_i);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_n_i |=> !err_n_i);
endmodule

bind mod_clk_sync_ctrl mcs_checker #(.DEC_W(DEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pd_i        (pd_q),
  .mclk_i      (mclk_o),
  .bit_vld_i   (bit_vld_o),
  .clr_i       (clr_o),
  .dec_phase_i (dec_phase_o),
  .err_evt_i   (err_evt_o),
  .err_n_i     (err_n_o)
);

// File: tb/tb_mod_clk_sync_ctrl.sv
`timescale 1ns/1ps
module tb_mod_clk_sync_ctrl;
  localparam int DEC_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pwrdn = 1'b0, sync = 1'b0, src_sel = 1'b0;
  logic             mdata = 1'b0, tdata = 1'b0, mflg = 1'b0;
  logic [DEC_W-1:0] ratio = 8'd5;
  logic             mclk, bit_vld, bitv, clr, err_evt, err_n;
  logic [DEC_W-1:0] dec_phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mod_clk_sync_ctrl #(.DEC_W(DEC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwrdn_i(pwrdn), .sync_i(sync),
    .src_sel_i(src_sel), .mdata_i(mdata), .tdata_i(tdata), .mflg_i(mflg),
    .ratio_i(ratio), .mclk_o(mclk), .bit_vld_o(bit_vld), .bit_o(bitv),
    .clr_o(clr), .dec_phase_o(dec_phase), .err_evt_o(err_evt), .err_n_o(err_n)
  );

  // reference model built from the requirements
  logic [1:0]       m_div;
  logic [DEC_W-1:0] m_dec;
  logic             m_halt, m_pd, m_syncq, m_flgq;
  logic             m_vld, m_bit, m_clr, m_evt, m_errn;

  always @(negedge clk or negedge rst_ni) begin
    if (!rst_ni) m_pd <= 1'b0;
    else         m_pd <= pwrdn;
  end

  always @(posedge clk or negedge rst_ni) begin : model
    logic take, clr_now;
    if (!rst_ni) begin
      m_div <= 2'd0; m_dec <= '0; m_halt <= 1'b0; m_syncq <= 1'b0;
      m_flgq <= 1'b0; m_vld <= 1'b0; m_bit <= 1'b0; m_clr <= 1'b0;
      m_evt <= 1'b0; m_errn <= 1'b1;
    end else begin
      take    = !m_pd && !m_halt && (m_div == 2'd3);
      clr_now = !m_pd && sync && !m_syncq && (m_halt || m_dec != 0);
      m_vld   <= take;
      if (take) m_bit <= src_sel ? tdata : mdata;
      m_clr   <= clr_now;
      m_syncq <= sync;
      if (m_pd) begin
        m_halt <= 1'b1;
      end else begin
        m_div <= m_div + 2'd1;
        if (clr_now) begin
          m_dec <= '0; m_halt <= 1'b0;
        end else if (take) begin
          m_dec <= (int'(m_dec) + 1 >= int'(ratio)) ? '0 : m_dec + 1'b1;
        end
      end
      m_flgq <= mflg;
      m_evt  <= mflg && !m_flgq;
      if (mflg) m_errn <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      string ph_req;
      ph_req = m_pd ? "R6" : (m_halt ? "R7" : "R4");
      chk(m_pd ? "R6" : "R1", "mclk", mclk, (m_div < 2'd2) ? 1 : 0);
      chk(m_pd ? "R6" : "R2", "bit_vld", bit_vld, m_vld);
      chk("R3", "bit", bitv, m_bit);
      chk(ph_req, "dec_phase", dec_phase, m_dec);
      chk("R5", "clr", clr, m_clr);
      chk("R8", "err_evt", err_evt, m_evt);
      chk("R8", "err_n", err_n, m_errn);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic rnd_data();
    mdata = 1'($urandom);
    tdata = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    // R9: reset state, directly
    checks++; if (!(mclk && !bit_vld && !clr && dec_phase == 0 && err_n && !err_evt)) begin
      fails++; $display("FAIL R9 reset state actual=%b%b%b%0d%b expected=10001", mclk, bit_vld, clr, dec_phase, err_n);
    end
    rst_ni = 1'b1;
    // R4 default ratio, R3 both sources
    for (int i = 0; i < 60; i++) begin rnd_data(); src_sel = (i >= 30); cyc(1); end
    // R4 corner: ratio 1 and 0 keep phase at 0
    ratio = 8'd1; for (int i = 0; i < 24; i++) begin rnd_data(); cyc(1); end
    ratio = 8'd0; for (int i = 0; i < 24; i++) begin rnd_data(); cyc(1); end
    // R5: aligned sync is a no-op, misaligned sync clears
    ratio = 8'd4;
    for (int i = 0; i < 80; i++) begin rnd_data(); sync = (i % 9 == 0); cyc(1); end
    sync = 1'b0;
    // R6/R7: power-down, exit, halt, then sync restarts
    pwrdn = 1'b1; cyc(20); pwrdn = 1'b0; cyc(20);
    sync = 1'b1; cyc(1); sync = 1'b0; cyc(30);
    // R7: sync held high across exit must not restart
    pwrdn = 1'b1; cyc(5); sync = 1'b1; cyc(5); pwrdn = 1'b0; cyc(20);
    sync = 1'b0; cyc(3); sync = 1'b1; cyc(1); sync = 1'b0; cyc(20);
    // R8: overrange
    mflg = 1'b1; cyc(3); mflg = 1'b0; cyc(10);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      rnd_data();
      if ($urandom_range(15) == 0) src_sel = ~src_sel;
      sync = ($urandom_range(19) == 0);
      if ($urandom_range(63) == 0) pwrdn = ~pwrdn;
      mflg = ($urandom_range(199) == 0);
      if ($urandom_range(199) == 0) ratio = 8'($urandom_range(12));
      cyc(1);
    end
    // R9: mid-run reset clears the sticky error
    mflg = 1'b1; cyc(2); mflg = 1'b0; pwrdn = 1'b0;
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule